// File: doc/BRIEF.md
# Indirect Branch Target Cache

This block predicts the target address of indirect branches other than subroutine returns. It is a direct-mapped table of target entries that all hardware threads share. The fetch stage presents a fetch address together with a short history slice belonging to the requesting thread. The entry index is formed by XORing the word-index bits of that address with the history slice. One cycle later the block returns the stored target, the entry's confidence and a hit flag. The fetch stage should follow the target only when the hit flag is set.

When an indirect branch resolves, the execution side drives the update port with the same address and history slice as the lookup, plus the resolved target. A saturating 2-bit confidence counter in each entry controls the result. A matching target strengthens the counter. A mismatching target weakens it. The stored target is overwritten only when the counter has already dropped to zero. Both ports carry a return flag: lookups and updates for subroutine returns are rejected, because those branches belong to a different predictor.

Top module: `ind_tgt_cache`

## Requirements
- R1: The entry index is fetch address bits [8:2] XOR the 7-bit history slice. Address bits [1:0] and [63:9] have no effect on which entry is selected.
- R2: After reset every entry reads as empty: res_conf_o is 0 and res_hit_o is 0 for every index. A later reset empties the table again.
- R3: A lookup without the return flag, presented in cycle N, produces res_valid_o high in cycle N+1. In a cycle with no such lookup, res_valid_o is low.
- R4: An update that hits an empty entry stores the resolved target and sets the confidence to 1.
- R5: An update whose target equals the stored target raises the confidence by one. The confidence stays at 3 once it reaches 3.
- R6: An update whose target differs from the stored target lowers the confidence by one when the confidence is 1 or more. The stored target is kept.
- R7: A mismatching update on an entry with confidence 0 replaces the target and sets the confidence to 1.
- R8: res_hit_o is high only for a valid entry whose confidence is 2 or 3. For a valid entry, res_target_o is the stored 62-bit target with two zero bits appended below it.
- R9: A lookup with the return flag set produces no result (res_valid_o stays low). An update with the return flag set leaves the table unchanged.
- R10: A lookup and an update to the same entry in the same cycle return the entry as it was before that update.
- R11: The table is shared across threads. Different address and history pairs that hash to the same index read and train the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_is_ret_i | input | 1 | Lookup is for a subroutine return (rejected) |
| lk_addr_i | input | 64 | Fetch address of the lookup |
| lk_hist_i | input | 7 | History slice of the requesting thread |
| upd_valid_i | input | 1 | Update request from branch resolution |
| upd_is_ret_i | input | 1 | Update is for a subroutine return (ignored) |
| upd_addr_i | input | 64 | Fetch address of the resolved branch |
| upd_hist_i | input | 7 | History slice used at prediction time |
| upd_target_i | input | 64 | Resolved target address |
| res_valid_o | output | 1 | Lookup result present |
| res_hit_o | output | 1 | Prediction is confident enough to use |
| res_target_o | output | 64 | Predicted target |
| res_conf_o | output | 2 | Confidence of the selected entry (0 if empty) |

## Verification
On every cycle, the assertions check these properties. The result appears one cycle after the lookup. Return lookups produce nothing. A hit never comes with confidence below 2. Every training step moves the confidence by exactly one, or reloads it to 1 on replacement. A weakened entry keeps its target. A written entry becomes valid.

Only the bench scenarios can show the rest. These include the index hash and the aliasing between threads, the saturation at 3, and the ordering when a lookup and an update hit the same entry in one cycle. They also cover the fact that a return-flagged update leaves the stored state untouched. A reset in the middle of a run must empty the whole table again.

// File: rtl/ind_tgt_pkg.sv
package ind_tgt_pkg;
  localparam int unsigned CONF_W   = 2;
  localparam logic [CONF_W-1:0] CONF_MAX = 2'd3;
  localparam logic [CONF_W-1:0] CONF_USE = 2'd2;
  localparam logic [CONF_W-1:0] CONF_NEW = 2'd1;

  typedef enum logic [2:0] {
    UPD_ALLOC,
    UPD_STRONGER,
    UPD_WEAKER,
    UPD_REPLACE
  } upd_kind_e;
endpackage

// File: rtl/ind_tgt_index.sv
module ind_tgt_index #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  hist_i,
  output logic [IDX_W-1:0]  idx_o
);
  // word-aligned: skip the two byte-offset bits
  logic unused_addr;
  assign unused_addr = ^{addr_i[ADDR_W-1:IDX_W+2], addr_i[1:0]};
  assign idx_o = addr_i[IDX_W+1:2] ^ hist_i;
endmodule

// File: rtl/ind_tgt_policy.sv
module ind_tgt_policy
  import ind_tgt_pkg::*;
#(
  parameter int unsigned TGT_W = 62
) (
  input  logic              cur_vld_i,
  input  logic [CONF_W-1:0] cur_conf_i,
  input  logic [TGT_W-1:0]  cur_tgt_i,
  input  logic [TGT_W-1:0]  res_tgt_i,
  output logic [CONF_W-1:0] nxt_conf_o,
  output logic [TGT_W-1:0]  nxt_tgt_o
);
  upd_kind_e kind;

  always_comb begin
    if (!cur_vld_i)                   kind = UPD_ALLOC;
    else if (cur_tgt_i == res_tgt_i)  kind = UPD_STRONGER;
    else if (cur_conf_i != '0)        kind = UPD_WEAKER;
    else                              kind = UPD_REPLACE;
  end

  always_comb begin
    nxt_conf_o = cur_conf_i;
    nxt_tgt_o  = cur_tgt_i;
    unique case (kind)
      UPD_ALLOC, UPD_REPLACE: begin
        nxt_conf_o = CONF_NEW;
        nxt_tgt_o  = res_tgt_i;
      end
      UPD_STRONGER: if (cur_conf_i != CONF_MAX) nxt_conf_o = cur_conf_i + 1'b1;
      UPD_WEAKER:   nxt_conf_o = cur_conf_i - 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ind_tgt_store.sv
module ind_tgt_store
  import ind_tgt_pkg::*;
#(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned TGT_W   = 62,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_q_o,
  output logic [CONF_W-1:0] rd_conf_q_o,
  output logic [TGT_W-1:0]  rd_tgt_q_o,
  input  logic [IDX_W-1:0]  pk_idx_i,
  output logic              pk_vld_o,
  output logic [CONF_W-1:0] pk_conf_o,
  output logic [TGT_W-1:0]  pk_tgt_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CONF_W-1:0] wr_conf_i,
  input  logic [TGT_W-1:0]  wr_tgt_i
);
  logic [ENTRIES-1:0] vld_q;
  logic [CONF_W-1:0]  conf_q [ENTRIES];
  logic [TGT_W-1:0]   tgt_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit_wr;
    assign hit_wr = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     vld_q[e] <= 1'b0;
      else if (hit_wr) vld_q[e] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit_wr) begin
        conf_q[e] <= wr_conf_i;
        tgt_q[e]  <= wr_tgt_i;
      end
    end
  end

  assign pk_vld_o  = vld_q[pk_idx_i];
  assign pk_conf_o = conf_q[pk_idx_i];
  assign pk_tgt_o  = tgt_q[pk_idx_i];

  // read port sees pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q_o  <= 1'b0;
      rd_conf_q_o <= '0;
      rd_tgt_q_o  <= '0;
    end else begin
      rd_vld_q_o  <= vld_q[rd_idx_i];
      rd_conf_q_o <= conf_q[rd_idx_i];
      rd_tgt_q_o  <= tgt_q[rd_idx_i];
    end
  end

  assert_alloc_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_idx_i)]);
endmodule

// File: rtl/ind_tgt_cache.sv
module ind_tgt_cache
  import ind_tgt_pkg::*;
#(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned ADDR_W  = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TGT_W  = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic              lk_is_ret_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [IDX_W-1:0]  lk_hist_i,
  input  logic              upd_valid_i,
  input  logic              upd_is_ret_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [IDX_W-1:0]  upd_hist_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [ADDR_W-1:0] res_target_o,
  output logic [CONF_W-1:0] res_conf_o
);
  logic [IDX_W-1:0]  lk_idx, upd_idx;
  logic              upd_go, res_q;
  logic              cur_vld, rd_vld;
  logic [CONF_W-1:0] cur_conf, nxt_conf, rd_conf;
  logic [TGT_W-1:0]  cur_tgt, nxt_tgt, rd_tgt, res_tgt;
  logic              unused_tgt;

  assign unused_tgt = ^upd_target_i[1:0];
  assign res_tgt    = upd_target_i[ADDR_W-1:2];
  assign upd_go     = upd_valid_i && !upd_is_ret_i;

  ind_tgt_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_idx (
    .addr_i(lk_addr_i), .hist_i(lk_hist_i), .idx_o(lk_idx));

  ind_tgt_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_idx (
    .addr_i(upd_addr_i), .hist_i(upd_hist_i), .idx_o(upd_idx));

  ind_tgt_store #(.ENTRIES(ENTRIES), .TGT_W(TGT_W)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_idx), .rd_vld_q_o(rd_vld), .rd_conf_q_o(rd_conf), .rd_tgt_q_o(rd_tgt),
    .pk_idx_i(upd_idx), .pk_vld_o(cur_vld), .pk_conf_o(cur_conf), .pk_tgt_o(cur_tgt),
    .wr_en_i(upd_go), .wr_idx_i(upd_idx), .wr_conf_i(nxt_conf), .wr_tgt_i(nxt_tgt));

  ind_tgt_policy #(.TGT_W(TGT_W)) u_policy (
    .cur_vld_i(cur_vld), .cur_conf_i(cur_conf), .cur_tgt_i(cur_tgt),
    .res_tgt_i(res_tgt), .nxt_conf_o(nxt_conf), .nxt_tgt_o(nxt_tgt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= 1'b0;
    else         res_q <= lk_valid_i && !lk_is_ret_i;
  end

  assign res_valid_o  = res_q;
  assign res_conf_o   = rd_vld ? rd_conf : '0;
  assign res_hit_o    = res_q && rd_vld && (rd_conf >= CONF_USE);
  assign res_target_o = {rd_tgt, 2'b00};

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !lk_is_ret_i) |=> res_valid_o);
  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !res_valid_o);
  assert_ret_lookup_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_is_ret_i) |=> !res_valid_o);
  assert_hit_conf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> (res_valid_o && res_conf_o >= CONF_USE));
  assert_conf_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_go && cur_vld) |-> ((nxt_conf == cur_conf + 2'd1) || (nxt_conf + 2'd1 == cur_conf)
                             || (nxt_conf == CONF_MAX && cur_conf == CONF_MAX)
                             || (cur_conf == '0 && nxt_conf == CONF_NEW)));
  assert_keep_tgt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_go && cur_vld && cur_conf != '0) |-> nxt_tgt == cur_tgt);
  assert_replace_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_go && cur_vld && cur_conf == '0 && cur_tgt != res_tgt)
      |-> (nxt_tgt == res_tgt && nxt_conf == CONF_NEW));
endmodule

// File: tb/ind_tgt_cache_test.sv
module ind_tgt_cache_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, lk_is_ret = 0, upd_valid = 0, upd_is_ret = 0;
  logic [63:0] lk_addr = '0, upd_addr = '0, upd_target = '0;
  logic [6:0]  lk_hist = '0, upd_hist = '0;
  logic        res_valid, res_hit;
  logic [63:0] res_target;
  logic [1:0]  res_conf;

  int n_tests = 0;
  int n_fail  = 0;

  logic        m_v [128];
  logic [61:0] m_t [128];
  logic [1:0]  m_c [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_tgt_cache uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_is_ret_i(lk_is_ret), .lk_addr_i(lk_addr), .lk_hist_i(lk_hist),
    .upd_valid_i(upd_valid), .upd_is_ret_i(upd_is_ret), .upd_addr_i(upd_addr),
    .upd_hist_i(upd_hist), .upd_target_i(upd_target),
    .res_valid_o(res_valid), .res_hit_o(res_hit), .res_target_o(res_target),
    .res_conf_o(res_conf));

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] tgt(input int i, input int k);
    return {32'hA500_0000 + 32'(i), 30'(k * 977 + i), 2'b00};
  endfunction

  // address whose word-index bits give entry e under history h, with noisy upper/low bits
  function automatic logic [63:0] addr_for(input int e, input logic [6:0] h, input int salt);
    logic [6:0] w;
    w = 7'(e) ^ h;
    return {32'(salt * 40503), 23'(salt), w, 2'(salt)};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 128; i++) begin m_v[i] = 0; m_t[i] = '0; m_c[i] = '0; end
  endtask

  task automatic step(input logic lv, input logic [63:0] la, input logic [6:0] lh, input logic lr,
                      input logic uv, input logic [63:0] ua, input logic [6:0] uh,
                      input logic [63:0] ut, input logic ur, input string tag);
    logic [6:0]  li, ui;
    logic        ev, eh;
    logic [1:0]  ec;
    logic [63:0] et;
    li = la[8:2] ^ lh;
    ev = m_v[li];
    ec = ev ? m_c[li] : 2'd0;
    eh = ev && (ec >= 2);
    et = {m_t[li], 2'b00};
    lk_valid = lv; lk_addr = la; lk_hist = lh; lk_is_ret = lr;
    upd_valid = uv; upd_addr = ua; upd_hist = uh; upd_target = ut; upd_is_ret = ur;
    @(negedge clk);
    lk_valid = 0; upd_valid = 0; lk_is_ret = 0; upd_is_ret = 0;
    if (uv && !ur) begin
      ui = ua[8:2] ^ uh;
      if (!m_v[ui]) begin m_v[ui] = 1; m_t[ui] = ut[63:2]; m_c[ui] = 2'd1; end
      else if (m_t[ui] == ut[63:2]) begin if (m_c[ui] != 2'd3) m_c[ui] = m_c[ui] + 2'd1; end
      else if (m_c[ui] == 2'd0) begin m_t[ui] = ut[63:2]; m_c[ui] = 2'd1; end
      else m_c[ui] = m_c[ui] - 2'd1;
    end
    if (lv && !lr) begin
      chk(res_valid === 1'b1, {tag, " valid"}, 64'(res_valid), 64'd1);
      chk(res_conf === ec, {tag, " conf"}, 64'(res_conf), 64'(ec));
      chk(res_hit === eh, {tag, " hit"}, 64'(res_hit), 64'(eh));
      if (ev) chk(res_target === et, {tag, " target"}, res_target, et);
    end else begin
      chk(res_valid === 1'b0, {tag, " no result"}, 64'(res_valid), 64'd0);
    end
  endtask

  task automatic look(input int e, input logic [6:0] h, input int salt, input string tag);
    step(1, addr_for(e, h, salt), h, 0, 0, '0, '0, '0, 0, tag);
  endtask

  task automatic train(input int e, input logic [6:0] h, input int salt, input logic [63:0] t);
    step(0, '0, '0, 0, 1, addr_for(e, h, salt), h, t, 0, "R3 idle");
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid === 1'b0, "R3 reset state", 64'(res_valid), 64'd0);

    for (int e = 0; e < 128; e++) look(e, 7'(e * 3), e, "R2 empty after reset");

    // R4/R1: allocate every entry with one history, read with another (R11 aliasing)
    for (int e = 0; e < 128; e++) train(e, 7'h55, e + 1, tgt(e, 0));
    for (int e = 0; e < 128; e++) look(e, 7'h2A, e + 7, "R4 R1 R11 alloc");

    // R5: strengthen up to saturation
    for (int k = 0; k < 3; k++) begin
      for (int e = 0; e < 128; e++) train(e, 7'(e + k), k * 5 + e, tgt(e, 0));
      for (int e = 0; e < 128; e++) look(e, 7'(k * 17), e, "R5 R8 strengthen");
    end

    // R6/R7: weaken entries 0..31 down to zero, then replace
    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 32; e++) train(e, 7'h11, e, tgt(e, 9));
      for (int e = 0; e < 32; e++) look(e, 7'h7F, e, k < 3 ? "R6 weaken" : "R7 replace");
    end

    // R9: return-flagged lookup gives nothing; return-flagged update changes nothing
    for (int e = 40; e < 48; e++) begin
      step(1, addr_for(e, 7'h03, e), 7'h03, 1, 0, '0, '0, '0, 0, "R9 ret lookup");
      step(0, '0, '0, 0, 1, addr_for(e, 7'h04, e), 7'h04, tgt(e, 33), 1, "R9 ret update");
      look(e, 7'h05, e, "R9 state unchanged");
    end

    // R10: lookup and matching update on same entry in one cycle (entry 0 has conf 1)
    for (int e = 0; e < 8; e++) begin
      step(1, addr_for(e, 7'h21, 3), 7'h21, 0, 1, addr_for(e, 7'h42, 4), 7'h42, tgt(e, 9), 0,
           "R10 same-cycle");
      look(e, 7'h00, 0, "R10 after update");
    end

    // R2: second reset empties the table again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    for (int e = 0; e < 128; e++) look(e, 7'h33, e, "R2 empty after second reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule